// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable integer N = B·P + A and emits one single-cycle pulse per N input cycles, ready to feed a phase comparator. It is built the way a synthesizer's feedback path is built: a dual-modulus prescaler divides by either P+1 or P. A swallow counter (A) selects the larger modulus for the first A prescaler periods of each output period. A main counter (B) ends the output period after B prescaler periods. The prescaler base P is chosen from four values by a two-bit select code.

New settings are written into a holding latch with a one-cycle load strobe. The active counters take the latched values only at a reload boundary, which is the end of an output period. An output period in progress therefore always completes with the settings it started with. A latched setting with B smaller than A, or with B equal to zero, cannot be realised. The block then raises an error flag and stops pulsing until a legal setting is loaded.

Top module: `swallow_divider`

## Requirements
- R1: During reset `div_pulse` and `cfg_err` are 0. The latch resets to select 0, A = 0, B = 1, so without any load the pulses come every 8 input cycles after reset is released.
- R2: The select code maps to the prescaler base as follows: 0 gives P = 8, 1 gives P = 16, 2 gives P = 32 and 3 gives P = 64.
- R3: For a legal setting (B ≥ 1 and B ≥ A), consecutive pulses are exactly B·P + A input cycles apart.
- R4: Each pulse lasts one input cycle.
- R5: The boundary settings divide correctly: A = B gives B·(P+1), A = 0 gives B·P, and B = 1 with A = 0 gives the minimum N = P.
- R6: A setting with A > B, or with B = 0, raises `cfg_err` at the next reload boundary. No pulse appears while the error persists.
- R7: Loading a legal setting while `cfg_err` is high clears the flag within a few cycles. Pulses then resume at the new ratio.
- R8: A load during an output period does not change that period's length. Changes on the value inputs without a load strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Strobe that captures the three setting inputs into the holding latch |
| p_sel | input | SEL_W (2) | Prescaler base select code |
| a_val | input | A_W (6) | Swallow count A |
| b_val | input | B_W (13) | Main count B |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | High while the active setting is illegal |

## Verification
The bench measures the interval between pulses for every prescaler base, for several random legal settings, and for the A = B, A = 0 and B = 1 edges. A design that ignored the extra cycle of the P+1 modulus would come out A cycles short; one that counted B including zero would come out one prescaler period long. It loads a new setting halfway through a period and checks that this period keeps the old length. A design that applied settings at once would truncate that period. It also drives illegal settings and then a recovery load: a design that missed the check would keep pulsing at a wrapped ratio, and one that latched the error would never resume.

// File: rtl/swd_pkg.sv
package swd_pkg;
  // Prescaler modulus for a base value, select code and swallow flag.
  function automatic int unsigned swd_modulus(int unsigned base, int unsigned sel, logic swallow);
    return (base << sel) + (swallow ? 32'd1 : 32'd0);
  endfunction
endpackage

// File: rtl/swd_cfg_latch.sv
module swd_cfg_latch #(
  parameter int A_W   = 6,
  parameter int B_W   = 13,
  parameter int SEL_W = 2,
  parameter int RST_B = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] s_in,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  output logic [SEL_W-1:0] s_q,
  output logic [A_W-1:0]   a_q,
  output logic [B_W-1:0]   b_q,
  output logic             legal
);
  localparam int CW = (A_W > B_W) ? A_W : B_W;
  logic [CW-1:0] a_x, b_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= '0;
      a_q <= '0;
      b_q <= B_W'(RST_B);
    end else if (load) begin
      s_q <= s_in;
      a_q <= a_in;
      b_q <= b_in;
    end
  end

  assign a_x   = CW'(a_q);
  assign b_x   = CW'(b_q);
  assign legal = (b_x != '0) && (a_x <= b_x);
endmodule

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [PRE_W-1:0] ld_val,
  output logic             tc
);
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst)
      pre <= '0;
    else if (restart || (run && tc))
      pre <= ld_val;
    else if (run)
      pre <= pre - 1'b1;
  end

  assign tc = (pre == '0);
endmodule

// File: rtl/swd_counters.sv
module swd_counters #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic           step,
  input  logic [A_W-1:0] a_ld,
  input  logic [B_W-1:0] b_ld,
  output logic [A_W-1:0] a_cnt,
  output logic [B_W-1:0] b_cnt,
  output logic           last,
  output logic           a_nz_next
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_cnt <= '0;
      b_cnt <= '0;
    end else if (restart) begin
      a_cnt <= a_ld;
      b_cnt <= b_ld;
    end else if (step) begin
      if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
      b_cnt <= b_cnt - 1'b1;
    end
  end

  assign last = (b_cnt == B_W'(1));

  always_comb begin
    if (restart)
      a_nz_next = (a_ld != '0);
    else if (step)
      a_nz_next = (a_cnt > A_W'(1));
    else
      a_nz_next = (a_cnt != '0);
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int P_BASE = 8,
  parameter int SEL_W  = 2,
  parameter int A_W    = 6,
  parameter int B_W    = 13,
  parameter int RST_B  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] p_sel,
  input  logic [A_W-1:0]   a_val,
  input  logic [B_W-1:0]   b_val,
  output logic             div_pulse,
  output logic             cfg_err
);
  import swd_pkg::*;

  localparam int P_MAX = P_BASE << ((1 << SEL_W) - 1);
  localparam int PRE_W = $clog2(P_MAX + 2);

  logic [SEL_W-1:0] hold_s, sel_act, sel_next;
  logic [A_W-1:0]   hold_a, a_cnt;
  logic [B_W-1:0]   hold_b, b_cnt;
  logic             legal, tc, last, a_nz_next;
  logic             fresh, run, err_q, pulse_q;
  logic             end_hit, reload, step;
  logic [PRE_W-1:0] mod_m1;

  swd_cfg_latch #(.A_W(A_W), .B_W(B_W), .SEL_W(SEL_W), .RST_B(RST_B)) u_cfg (
    .clk(clk), .rst(rst), .load(load),
    .s_in(p_sel), .a_in(a_val), .b_in(b_val),
    .s_q(hold_s), .a_q(hold_a), .b_q(hold_b), .legal(legal)
  );

  swd_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .restart(reload), .run(run),
    .ld_val(mod_m1), .tc(tc)
  );

  swd_counters #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(reload), .step(step),
    .a_ld(hold_a), .b_ld(hold_b),
    .a_cnt(a_cnt), .b_cnt(b_cnt), .last(last), .a_nz_next(a_nz_next)
  );

  assign step     = run && tc;
  assign end_hit  = step && last;
  assign reload   = fresh || end_hit || err_q;
  assign sel_next = reload ? hold_s : sel_act;
  assign mod_m1   = PRE_W'(swd_modulus(P_BASE, 32'(sel_next), a_nz_next) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh   <= 1'b1;
      run     <= 1'b0;
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
      sel_act <= '0;
    end else begin
      fresh   <= 1'b0;
      pulse_q <= end_hit;
      if (reload) begin
        run     <= legal;
        err_q   <= !legal;
        sel_act <= hold_s;
      end
    end
  end

  assign div_pulse = pulse_q;
  assign cfg_err   = err_q;
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int P_BASE = 8,
  parameter int A_W    = 6,
  parameter int B_W    = 13
) (
  input logic           clk,
  input logic           rst,
  input logic           div_pulse,
  input logic           cfg_err,
  input logic           run,
  input logic [A_W-1:0] a_cnt,
  input logic [B_W-1:0] b_cnt,
  input logic [A_W-1:0] hold_a,
  input logic [B_W-1:0] hold_b
);
  localparam int CW    = (A_W > B_W) ? A_W : B_W;
  localparam int GAP_W = 16;

  logic [GAP_W-1:0] gap;
  logic             seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (div_pulse) begin
      gap  <= GAP_W'(1);
      seen <= 1'b1;
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  // R4: a pulse never lasts two cycles
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R6: no pulse while an error persists
  assert_err_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && $past(cfg_err)) |-> !div_pulse);

  // R6: the error flag only rises for an illegal latched setting
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |-> ($past(hold_b) == '0 || CW'($past(hold_a)) > CW'($past(hold_b))));

  // R3: swallow count never exceeds main count while dividing
  assert_swallow_order_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (CW'(a_cnt) <= CW'(b_cnt)));

  // R3: pulses are at least one base prescaler period apart
  assert_min_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (div_pulse && seen) |-> (gap >= GAP_W'(P_BASE)));
endmodule

bind swallow_divider swd_checker #(.P_BASE(P_BASE), .A_W(A_W), .B_W(B_W)) u_chk (
  .clk(clk), .rst(rst), .div_pulse(div_pulse), .cfg_err(cfg_err), .run(run),
  .a_cnt(a_cnt), .b_cnt(b_cnt), .hold_a(hold_a), .hold_b(hold_b)
);

// File: tb/sim_swallow_divider.sv
`timescale 1ns/1ps
module sim_swallow_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [1:0]  p_sel = '0;
  logic [5:0]  a_val = '0;
  logic [12:0] b_val = '0;
  logic        div_pulse, cfg_err;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  swallow_divider u0 (
    .clk(clk), .rst(rst), .load(load), .p_sel(p_sel),
    .a_val(a_val), .b_val(b_val), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic prog(input int sel, input int a, input int b);
    @(negedge clk);
    p_sel = 2'(sel); a_val = 6'(a); b_val = 13'(b); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_pulse();
    int n = 0;
    do begin @(negedge clk); n++; end while (!div_pulse && n < 5000);
  endtask

  task automatic measure(input int exp, input string tag);
    int cnt = 0;
    wait_pulse();
    do begin @(negedge clk); cnt++; end while (!div_pulse && cnt < 5000);
    chk(cnt == exp, tag, cnt, exp);
    @(negedge clk);
    chk(div_pulse == 1'b0, "R4 pulse width", int'(div_pulse), 0);
  endtask

  function automatic int nval(int sel, int a, int b);
    return b * (8 << sel) + a;
  endfunction

  task automatic t_reset();
    repeat (5) begin
      @(negedge clk);
      chk(div_pulse == 1'b0 && cfg_err == 1'b0, "R1 reset outputs", int'({div_pulse, cfg_err}), 0);
    end
    rst = 1'b0;
    measure(8, "R1 default ratio");
  endtask

  task automatic t_sel();
    for (int s = 0; s < 4; s++) begin
      prog(s, 3, 5);
      wait_pulse();
      measure(nval(s, 3, 5), "R2 select code");
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 6; i++) begin
      int s = int'($urandom_range(1, 0));
      int b = int'($urandom_range(40, 1));
      int a = int'($urandom_range(b, 0));
      prog(s, a, b);
      wait_pulse();
      measure(nval(s, a, b), "R3 random legal");
    end
  endtask

  task automatic t_edges();
    prog(0, 7, 7);  wait_pulse(); measure(63,  "R5 A equals B");
    prog(1, 0, 9);  wait_pulse(); measure(144, "R5 A zero");
    prog(0, 1, 1);  wait_pulse(); measure(9,   "R5 B one A one");
    prog(0, 0, 1);  wait_pulse(); measure(8,   "R5 minimum ratio");
  endtask

  task automatic t_midload();
    int cnt = 1;
    prog(0, 2, 10);
    wait_pulse();
    measure(82, "R8 setup ratio");
    do begin
      @(negedge clk); cnt++;
      if (cnt == 20) begin p_sel = 2'd0; a_val = 6'd1; b_val = 13'd3; load = 1'b1; end
      if (cnt == 21) load = 1'b0;
    end while (!div_pulse && cnt < 5000);
    chk(cnt == 82, "R8 period kept after mid-period load", cnt, 82);
    measure(25, "R8 new ratio after boundary");
    a_val = 6'd0; b_val = 13'd50; p_sel = 2'd3;
    wait_pulse();
    measure(25, "R8 inputs ignored without load");
  endtask

  task automatic t_illegal();
    int pulses = 0;
    prog(0, 5, 3);
    repeat (100) @(negedge clk);
    chk(cfg_err == 1'b1, "R6 A greater than B flags", int'(cfg_err), 1);
    repeat (300) begin @(negedge clk); if (div_pulse) pulses++; end
    chk(pulses == 0, "R6 no pulse while illegal", pulses, 0);
    prog(0, 0, 0);
    pulses = 0;
    repeat (50) begin @(negedge clk); if (div_pulse) pulses++; end
    chk(cfg_err == 1'b1, "R6 B zero flags", int'(cfg_err), 1);
    chk(pulses == 0, "R6 no pulse with B zero", pulses, 0);
  endtask

  task automatic t_recover();
    prog(0, 1, 2);
    repeat (3) @(negedge clk);
    chk(cfg_err == 1'b0, "R7 error clears", int'(cfg_err), 0);
    measure(17, "R7 ratio after recovery");
  endtask

  initial begin
    void'($urandom(7));
    t_reset();
    t_sel();
    t_random();
    t_edges();
    t_midload();
    t_illegal();
    t_recover();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule